// File: doc/BRIEF.md
# Read-Data Sample Point Calibrator

This block picks the receive sampling delay for a double-data-rate serial flash read path. On a start request it walks the delay-tap setting upward through every tap. At each tap it issues one test read on an external read port and compares the returned word with a fixed expected pattern. Each result goes into a pass/fail map. While the sweep runs, the block tracks runs of consecutive passing taps. When the sweep ends it places the sampling tap at the middle of the longest run. A left guard tap sits two taps below the middle and a right guard tap two taps above it.

Once calibrated, the block watches two guard samplers placed at the left and right guard taps. A mismatch reported by the left guard means the data eye has moved toward later taps, so the block shifts all three settings up by one tap. A mismatch on the right guard shifts them down by one tap. This keeps the sampling point inside the eye as temperature and voltage drift, without running a full sweep again. The analog delay line lies outside the block. The block only drives the tap number, which goes to the sweep read while calibrating and to the sampling centre at all other times.

Top module: `sample_point_cal`

## Requirements
- R1: After `cal_start` is accepted in idle, the block issues exactly one single-cycle `rd_req` per tap, in ascending order from tap 0 to tap 63. `tap_sel` shows the tap under test while `rd_req` is high. The next request waits until `rd_valid` has answered the previous one.
- R2: Bit i of `pass_map` is 0 when the word returned for tap i equals the expected pattern in all 32 bits, and 1 otherwise. The map is cleared when a calibration starts.
- R3: The chosen region is the longest run of consecutive passing taps. When two runs are equally long, the one at lower taps is chosen.
- R4: When a calibration succeeds, `tap_centre` is the run start plus (run length − 1)/2 rounded down. `tap_left` is the centre minus 2 and `tap_right` is the centre plus 2. `cal_done` is high for exactly one cycle, in the cycle after the last read is accepted, and the new settings appear one cycle after `cal_done`.
- R5: If the longest run is shorter than 5 taps, `cal_fail` is set and all three settings keep their previous values. A later successful calibration clears `cal_fail`.
- R6: While idle, each cycle in which `guard_err_lo` is high and `guard_err_hi` is low raises all three settings by 1.
- R7: While idle, each cycle in which `guard_err_hi` is high and `guard_err_lo` is low lowers all three settings by 1.
- R8: A guard step that would move any setting below 0 or above 63 is skipped. A cycle with both guard errors high changes nothing.
- R9: While a calibration is running, guard errors have no effect on the result, and a repeated `cal_start` neither restarts nor disturbs the sweep.
- R10: After reset the settings are centre 32, left 30 and right 34, `cal_fail` is low, `cal_done` is low and `rd_req` is low.
- R11: Outside a calibration, `tap_sel` equals `tap_centre`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Request a calibration sweep (taken when idle) |
| cal_done | output | 1 | One-cycle pulse at the end of a sweep |
| rd_req | output | 1 | Test read request, one cycle per tap |
| rd_valid | input | 1 | Read data is valid |
| rd_data | input | 32 | Word returned by the test read |
| tap_sel | output | 6 | Delay tap to apply: sweep tap when calibrating, centre otherwise |
| guard_err_lo | input | 1 | Left guard sampler mismatch |
| guard_err_hi | input | 1 | Right guard sampler mismatch |
| tap_centre | output | 6 | Sampling tap |
| tap_left | output | 6 | Left guard tap |
| tap_right | output | 6 | Right guard tap |
| cal_fail | output | 1 | Last sweep found no run long enough |
| pass_map | output | 64 | Pass/fail map, 1 = mismatch |

## Verification
A corrupted run counter or run start shows as a wrong centre right after `cal_done`. The bench catches it within one sweep because it applies many pass masks with runs of known position and length, including equal-length runs and runs that touch either end of the tap range. A tap index that skips or repeats shows at once in the logged request sequence. A bad guard-step condition shows one cycle after a single guard error pulse, and the bench tests this at both range limits. A state machine that leaks guard errors into a running sweep shows in the settings reported after that sweep.

// File: rtl/sampcal_pkg.sv
package sampcal_pkg;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_ISSUE = 2'd1,
        SW_WAIT  = 2'd2,
        SW_DONE  = 2'd3
    } sweep_st_e;

endpackage

// File: rtl/sampcal_sweep.sv
module sampcal_sweep
    import sampcal_pkg::*;
#(
    parameter int          TAP_W   = 6,
    parameter int          DATA_W  = 32,
    parameter logic [31:0] PATTERN = 32'hA5C3_3C5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic              busy,
    output logic              clr,
    output logic              finish,
    output logic [TAP_W-1:0]  sweep_tap,
    output logic              smp_valid,
    output logic              smp_fail
);

    localparam logic [TAP_W-1:0]  LAST_TAP = '1;
    localparam logic [DATA_W-1:0] EXP_WORD = DATA_W'(PATTERN);

    typedef struct packed {
        sweep_st_e        st;
        logic [TAP_W-1:0] idx;
    } sweep_s;

    sweep_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SW_IDLE: begin
                if (start) begin
                    r_d.idx = '0;
                    r_d.st  = SW_ISSUE;
                end
            end
            SW_ISSUE: r_d.st = SW_WAIT;
            SW_WAIT: begin
                if (rd_valid) begin
                    if (r_q.idx == LAST_TAP) begin
                        r_d.st = SW_DONE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = SW_ISSUE;
                    end
                end
            end
            SW_DONE: r_d.st = SW_IDLE;
            default: r_d.st = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SW_IDLE, idx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req    = (r_q.st == SW_ISSUE);
    assign busy      = (r_q.st != SW_IDLE);
    assign clr       = (r_q.st == SW_IDLE) && start;
    assign finish    = (r_q.st == SW_DONE);
    assign sweep_tap = r_q.idx;
    assign smp_valid = (r_q.st == SW_WAIT) && rd_valid;
    assign smp_fail  = (rd_data != EXP_WORD);

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req) else $error("request held");                      // R1
    AST_TAP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && sweep_tap != LAST_TAP) |=> (sweep_tap == $past(sweep_tap) + 1'b1))
        else $error("tap not ascending");                                     // R1
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy) else $error("sweep cut short");           // R9

endmodule

// File: rtl/sampcal_runfind.sv
module sampcal_runfind #(
    parameter int TAP_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               smp_valid,
    input  logic [TAP_W-1:0]   smp_idx,
    input  logic               smp_fail,
    output logic [(1<<TAP_W)-1:0] map,
    output logic [TAP_W-1:0]   best_start,
    output logic [TAP_W:0]     best_len
);

    localparam int NTAPS = 1 << TAP_W;

    typedef struct packed {
        logic [NTAPS-1:0] map;
        logic [TAP_W-1:0] cur_start;
        logic [TAP_W:0]   cur_len;
        logic [TAP_W-1:0] best_start;
        logic [TAP_W:0]   best_len;
    } run_s;

    run_s r_q, r_d;
    logic [TAP_W-1:0] ns_start;
    logic [TAP_W:0]   ns_len;

    always_comb begin
        r_d      = r_q;
        ns_start = (r_q.cur_len == '0) ? smp_idx : r_q.cur_start;
        ns_len   = r_q.cur_len + 1'b1;
        if (clr) begin
            r_d = '0;
        end else if (smp_valid) begin
            r_d.map[smp_idx] = smp_fail;
            if (smp_fail) begin
                r_d.cur_len = '0;
            end else begin
                r_d.cur_start = ns_start;
                r_d.cur_len   = ns_len;
                if (ns_len > r_q.best_len) begin
                    r_d.best_start = ns_start;
                    r_d.best_len   = ns_len;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign map        = r_q.map;
    assign best_start = r_q.best_start;
    assign best_len   = r_q.best_len;

    AST_BEST_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> r_q.best_len >= $past(r_q.best_len)) else $error("best shrank"); // R3
    AST_CUR_WITHIN_BEST: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cur_len <= r_q.best_len) else $error("run exceeds best");          // R3
    AST_FAIL_RESETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_fail && !clr) |=> r_q.cur_len == '0) else $error("run kept"); // R2

endmodule

// File: rtl/sampcal_guard.sv
module sampcal_guard #(
    parameter int TAP_W     = 6,
    parameter int GUARD_OFS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             finish,
    input  logic             run_ok,
    input  logic [TAP_W-1:0] new_centre,
    input  logic             err_lo,
    input  logic             err_hi,
    output logic [TAP_W-1:0] centre,
    output logic [TAP_W-1:0] left,
    output logic [TAP_W-1:0] right,
    output logic             fail
);

    localparam int               NTAPS  = 1 << TAP_W;
    localparam logic [TAP_W-1:0] MAXTAP = '1;
    localparam logic [TAP_W-1:0] OFS    = TAP_W'(GUARD_OFS);
    localparam logic [TAP_W-1:0] RST_C  = TAP_W'(NTAPS / 2);

    typedef struct packed {
        logic [TAP_W-1:0] centre;
        logic [TAP_W-1:0] left;
        logic [TAP_W-1:0] right;
        logic             fail;
    } guard_s;

    guard_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (finish) begin
            if (run_ok) begin
                r_d.centre = new_centre;
                r_d.left   = new_centre - OFS;
                r_d.right  = new_centre + OFS;
                r_d.fail   = 1'b0;
            end else begin
                r_d.fail   = 1'b1;
            end
        end else if (!busy) begin
            if (err_lo && !err_hi && r_q.right != MAXTAP) begin
                r_d.centre = r_q.centre + 1'b1;
                r_d.left   = r_q.left + 1'b1;
                r_d.right  = r_q.right + 1'b1;
            end else if (err_hi && !err_lo && r_q.left != '0) begin
                r_d.centre = r_q.centre - 1'b1;
                r_d.left   = r_q.left - 1'b1;
                r_d.right  = r_q.right - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{centre: RST_C, left: RST_C - OFS, right: RST_C + OFS, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign centre = r_q.centre;
    assign left   = r_q.left;
    assign right  = r_q.right;
    assign fail   = r_q.fail;

    AST_GUARD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.right - r_q.centre == OFS) && (r_q.centre - r_q.left == OFS))
        else $error("guard spread lost");                                     // R4
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !finish && err_lo && !err_hi && r_q.right != MAXTAP)
        |=> r_q.centre == TAP_W'($past(r_q.centre) + 1'b1)) else $error("no up step");   // R6
    AST_RIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !finish && err_hi && !err_lo && r_q.left != '0)
        |=> r_q.centre == TAP_W'($past(r_q.centre) - 1'b1)) else $error("no down step"); // R7
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!finish && ((err_lo && r_q.right == MAXTAP) || (err_hi && r_q.left == '0)
                     || (err_lo && err_hi)))
        |=> $stable(r_q.centre)) else $error("edge step taken");              // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(r_q.centre)) else $error("moved in sweep"); // R9
    AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !run_ok) |=> (r_q.fail && $stable(r_q.centre))) else $error("fail path"); // R5

endmodule

// File: rtl/sample_point_cal.sv
module sample_point_cal #(
    parameter int          TAP_W     = 6,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] PATTERN   = 32'hA5C3_3C5A,
    parameter int          GUARD_OFS = 2,
    parameter int          MIN_RUN   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cal_start,
    output logic                  cal_done,
    output logic                  rd_req,
    input  logic                  rd_valid,
    input  logic [DATA_W-1:0]     rd_data,
    output logic [TAP_W-1:0]      tap_sel,
    input  logic                  guard_err_lo,
    input  logic                  guard_err_hi,
    output logic [TAP_W-1:0]      tap_centre,
    output logic [TAP_W-1:0]      tap_left,
    output logic [TAP_W-1:0]      tap_right,
    output logic                  cal_fail,
    output logic [(1<<TAP_W)-1:0] pass_map
);

    localparam int             NTAPS   = 1 << TAP_W;
    localparam logic [TAP_W:0] MIN_LEN = (TAP_W+1)'(MIN_RUN);

    logic             busy, clr, finish, smp_valid, smp_fail;
    logic [TAP_W-1:0] sweep_tap, best_start, centre;
    logic [TAP_W:0]   best_len, mid_w;
    logic             run_ok;

    sampcal_sweep #(.TAP_W(TAP_W), .DATA_W(DATA_W), .PATTERN(PATTERN)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cal_start),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .busy      (busy),
        .clr       (clr),
        .finish    (finish),
        .sweep_tap (sweep_tap),
        .smp_valid (smp_valid),
        .smp_fail  (smp_fail)
    );

    sampcal_runfind #(.TAP_W(TAP_W)) u_runfind (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .smp_valid  (smp_valid),
        .smp_idx    (sweep_tap),
        .smp_fail   (smp_fail),
        .map        (pass_map),
        .best_start (best_start),
        .best_len   (best_len)
    );

    assign run_ok = (best_len >= MIN_LEN);
    assign mid_w  = {1'b0, best_start} + ((best_len - 1'b1) >> 1);

    sampcal_guard #(.TAP_W(TAP_W), .GUARD_OFS(GUARD_OFS)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .finish     (finish),
        .run_ok     (run_ok),
        .new_centre (mid_w[TAP_W-1:0]),
        .err_lo     (guard_err_lo),
        .err_hi     (guard_err_hi),
        .centre     (centre),
        .left       (tap_left),
        .right      (tap_right),
        .fail       (cal_fail)
    );

    assign tap_centre = centre;
    assign tap_sel    = busy ? sweep_tap : centre;
    assign cal_done   = finish;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done) else $error("done too long");                 // R4
    AST_MID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && run_ok) |-> (!mid_w[TAP_W] && best_len <= (TAP_W+1)'(NTAPS)))
        else $error("centre out of range");                                    // R4
    AST_MIN_RUN_GUARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && run_ok) |-> (mid_w >= (TAP_W+1)'(GUARD_OFS)))
        else $error("guard underflow");                                        // R5

endmodule

// File: tb/sample_point_cal_test.sv
module sample_point_cal_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] PAT        = 32'hA5C3_3C5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic        cal_done;
    logic        rd_req;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic [5:0]  tap_sel;
    logic        guard_err_lo = 1'b0;
    logic        guard_err_hi = 1'b0;
    logic [5:0]  tap_centre, tap_left, tap_right;
    logic        cal_fail;
    logic [63:0] pass_map;

    int checks = 0;
    int fails  = 0;
    logic [63:0] cur_mask = '0;
    int req_count = 0;
    int seq_err = 0;
    logic pending = 1'b0;
    logic [5:0] pend_tap = '0;
    int exp_c = 32;

    sample_point_cal uut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_done(cal_done),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .tap_sel(tap_sel),
        .guard_err_lo(guard_err_lo), .guard_err_hi(guard_err_hi),
        .tap_centre(tap_centre), .tap_left(tap_left), .tap_right(tap_right),
        .cal_fail(cal_fail), .pass_map(pass_map)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // read responder: answers each request two negedges later
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (pending) begin
                rd_valid = 1'b1;
                rd_data  = cur_mask[pend_tap] ? PAT : (PAT ^ 32'h0000_0100);
                pending  = 1'b0;
            end else if (rd_req) begin
                if (int'(tap_sel) != req_count) seq_err++;
                req_count++;
                pend_tap = tap_sel;
                pending  = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [63:0] win(input int lo, input int len);
        logic [63:0] m = '0;
        for (int i = lo; i < lo + len && i < 64; i++) m[i] = 1'b1;
        return m;
    endfunction

    // expected centre of the longest (lowest on tie) passing run, -1 if too short
    function automatic int expect_centre(input logic [63:0] m);
        int bs = 0, bl = 0, cs = 0, cl = 0;
        for (int i = 0; i < 64; i++) begin
            if (m[i]) begin
                if (cl == 0) cs = i;
                cl++;
                if (cl > bl) begin bl = cl; bs = cs; end
            end else cl = 0;
        end
        return (bl >= 5) ? bs + (bl - 1) / 2 : -1;
    endfunction

    task automatic check_taps(input string tag, input int c);
        check({tag, " centre"}, 64'(tap_centre), 64'(c));
        check({tag, " left"},   64'(tap_left),   64'(c - 2));
        check({tag, " right"},  64'(tap_right),  64'(c + 2));
    endtask

    task automatic run_cal(input logic [63:0] m, input bit noisy);
        int ec;
        int wait_n = 0;
        cur_mask = m;
        req_count = 0;
        seq_err = 0;
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        while (!cal_done && wait_n < 1000) begin
            if (noisy) begin
                guard_err_lo = (wait_n % 3) == 0;
                guard_err_hi = (wait_n % 7) == 0;
                cal_start    = (wait_n % 11) == 5;
            end
            @(negedge clk);
            wait_n++;
        end
        guard_err_lo = 1'b0;
        guard_err_hi = 1'b0;
        cal_start    = 1'b0;
        check("R4 done seen", 64'(cal_done), 64'd1);
        check("R1 request count", 64'(req_count), 64'd64);
        check("R1 tap order", 64'(seq_err), 64'd0);
        check("R2 map", pass_map, ~m);
        @(negedge clk);
        check("R4 done one cycle", 64'(cal_done), 64'd0);
        ec = expect_centre(m);
        if (ec >= 0) begin
            exp_c = ec;
            check("R5 fail clear", 64'(cal_fail), 64'd0);
        end else begin
            check("R5 fail set", 64'(cal_fail), 64'd1);
        end
        check_taps(noisy ? "R9 busy" : "R3 R4", exp_c);
        check("R11 tap_sel idle", 64'(tap_sel), 64'(exp_c));
    endtask

    task automatic guard_pulse(input logic lo, input logic hi, input int exp_after, input string tag);
        @(negedge clk);
        guard_err_lo = lo;
        guard_err_hi = hi;
        @(negedge clk);
        guard_err_lo = 1'b0;
        guard_err_hi = 1'b0;
        exp_c = exp_after;
        check_taps(tag, exp_c);
        check("R11 tap_sel after guard", 64'(tap_sel), 64'(exp_c));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 centre", 64'(tap_centre), 64'd32);
        check("R10 left", 64'(tap_left), 64'd30);
        check("R10 right", 64'(tap_right), 64'd34);
        check("R10 fail", 64'(cal_fail), 64'd0);
        check("R10 done", 64'(cal_done), 64'd0);
        check("R10 req", 64'(rd_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 tap_sel reset", 64'(tap_sel), 64'd32);

        run_cal(win(20, 11), 1'b0);                         // centre 25
        run_cal(win(5, 8) | win(40, 8), 1'b0);              // R3 tie, lower wins -> 8
        run_cal(win(10, 4), 1'b0);                          // R5 too short, keeps 8
        run_cal(win(2, 3) | win(30, 6) | win(50, 9), 1'b0); // R3 longest is upper -> 54
        run_cal('1, 1'b0);                                  // full range -> 31
        for (int k = 0; k < 12; k++) begin
            run_cal(win((k * 7) % 40, 5 + k) | win(52, 3 + k % 5), 1'b0);
        end

        // upper edge: run 59..63 -> centre 61, right at 63
        run_cal(win(59, 5), 1'b0);
        guard_pulse(1'b1, 1'b0, 61, "R8 upper skip");
        guard_pulse(1'b1, 1'b1, 61, "R8 both");
        guard_pulse(1'b0, 1'b1, 60, "R7 down");
        guard_pulse(1'b1, 1'b0, 61, "R6 up");

        // lower edge: run 0..4 -> centre 2, left at 0
        run_cal(win(0, 5), 1'b0);
        guard_pulse(1'b0, 1'b1, 2, "R8 lower skip");
        guard_pulse(1'b1, 1'b0, 3, "R6 up");
        guard_pulse(1'b1, 1'b0, 4, "R6 up again");
        guard_pulse(1'b0, 1'b1, 3, "R7 down");

        // guard errors and repeated start during a sweep
        run_cal(win(12, 9), 1'b1);                          // centre 16
        run_cal(win(60, 2), 1'b1);                          // fail, keeps 16

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule